// File: doc/BRIEF.md
# Control Pin Qualifier

This block sits between the slow mode-select pins of a broadcast data receiver and the logic that uses them. It filters the raw reset pin, the error-correction enable pin and the start-strobe mode pin, and latches the output clock polarity pin once after reset. The filtered values are registered and remain stable, so downstream logic never sees a glitch or a half-changed mode.

The two live controls are sampled only at chosen instants. While the receiver is still hunting for lock, every incoming data bit strobe is a sample point. Once it is locked, only the block-boundary strobe is a sample point. A filtered value takes a new level only after several consecutive samples of the pin agree. The polarity pin is read once, a fixed number of system clocks after the internal reset ends, and is held until the next reset. The reset pin itself must stay low for a minimum number of clocks before the internal reset is asserted.

Top module: `ctl_qual`

## Requirements
- R1: `rst_out` goes high only after `rst_pin_n` has been low at RST_MIN consecutive rising clock edges. It then stays high until the first edge at which the pin is high, where it returns low. A shorter low pulse leaves `rst_out` low.
- R2: On the edge after any edge at which `rst_out` is high, the outputs take their defaults: `corr_en`=0 (correction off), `smode`=0 (start strobe on every block) and `pol_fall`=0 (data valid on the rising edge of the output clock).
- R3: A filtered live control (`corr_en`, `smode`) takes the pin level only at a sample instant where that level agrees with the last QUAL_LEN samples taken since reset. A broken run restarts the count.
- R4: While `locked`=0, a sample is taken on every edge where `bit_stb`=1. `blk_stb` has no effect.
- R5: While `locked`=1, a sample is taken on every edge where `blk_stb`=1. `bit_stb` has no effect.
- R6: The two live controls are qualified independently and can change at any time during operation, in either state.
- R7: `pol_fall` loads `pol_pin` at the POL_DELAY-th rising edge after `rst_out` falls. It holds that value, whatever the pin does, until the next reset.
- R8: The internal reset discards every sample history. Samples taken before it do not count toward a later qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Raw active-low reset pin |
| bit_stb | input | 1 | One-clock strobe per received data bit |
| blk_stb | input | 1 | One-clock strobe at each received block start |
| locked | input | 1 | 1 when the receiver holds group lock |
| corr_pin | input | 1 | Raw error-correction enable pin (1 = enable) |
| smode_pin | input | 1 | Raw start-strobe mode pin (1 = second block only) |
| pol_pin | input | 1 | Raw output clock polarity pin (1 = falling-edge valid) |
| rst_out | output | 1 | Qualified internal reset, active high |
| corr_en | output | 1 | Filtered correction enable |
| smode | output | 1 | Filtered start-strobe mode |
| pol_fall | output | 1 | Latched output clock polarity |

## Verification
The bench builds the block with QUAL_LEN=4 and RST_MIN=4, as the defaults give. POL_DELAY is cut from 4000 to 40. With the shorter delay, the polarity capture instant, the hold after capture, repeated resets and thousands of cycles of random pins and strobes all fit in a short run. The random phase crosses lock changes, broken sample runs and reset pulses on both sides of the four-clock minimum.

// File: rtl/ctl_qual.sv
module ctl_qual #(
  parameter int QUAL_LEN  = 4,
  parameter int RST_MIN   = 4,
  parameter int POL_DELAY = 4000
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic bit_stb,
  input  logic blk_stb,
  input  logic locked,
  input  logic corr_pin,
  input  logic smode_pin,
  input  logic pol_pin,
  output logic rst_out,
  output logic corr_en,
  output logic smode,
  output logic pol_fall
);
  localparam int RW = (RST_MIN > 1) ? $clog2(RST_MIN) : 1;
  localparam int TW = (POL_DELAY > 1) ? $clog2(POL_DELAY) : 1;
  localparam int FW = $clog2(QUAL_LEN + 1);

  logic [RW-1:0] low_cnt;

  always_ff @(posedge clk)
    if (rst_pin_n) begin
      low_cnt <= '0;
      rst_out <= 1'b0;
    end else if (low_cnt == RW'(RST_MIN - 1)) begin
      rst_out <= 1'b1;
    end else begin
      low_cnt <= low_cnt + RW'(1);
    end

  logic       smp;
  logic [1:0] live_pin, live_q;

  assign smp      = locked ? blk_stb : bit_stb;
  assign live_pin = {smode_pin, corr_pin};

  for (genvar i = 0; i < 2; i++) begin : g_live
    logic [QUAL_LEN-2:0] hist;
    logic [FW-1:0]       fill;
    logic [QUAL_LEN-1:0] nxt;
    logic                q;

    assign nxt = {hist, live_pin[i]};

    always_ff @(posedge clk)
      if (rst_out) begin
        hist <= '0;
        fill <= '0;
        q    <= 1'b0;
      end else if (smp) begin
        hist <= nxt[QUAL_LEN-2:0];
        if (fill != FW'(QUAL_LEN)) fill <= fill + FW'(1);
        if (fill >= FW'(QUAL_LEN - 1) && (nxt == '0 || nxt == '1)) q <= live_pin[i];
      end

    assign live_q[i] = q;
  end

  assign corr_en = live_q[0];
  assign smode   = live_q[1];

  logic [TW-1:0] tmr;
  logic          pol_done;

  always_ff @(posedge clk)
    if (rst_out) begin
      tmr      <= '0;
      pol_done <= 1'b0;
      pol_fall <= 1'b0;
    end else if (!pol_done) begin
      if (tmr == TW'(POL_DELAY - 1)) begin
        pol_fall <= pol_pin;
        pol_done <= 1'b1;
      end else begin
        tmr <= tmr + TW'(1);
      end
    end
endmodule

// File: rtl/ctl_qual_chk.sv
module ctl_qual_chk #(
  parameter int QUAL_LEN  = 4,
  parameter int RST_MIN   = 4,
  parameter int POL_DELAY = 4000
) (
  input logic clk,
  input logic rst_pin_n,
  input logic bit_stb,
  input logic blk_stb,
  input logic locked,
  input logic corr_pin,
  input logic rst_out,
  input logic corr_en,
  input logic smode,
  input logic pol_fall
);
  logic [1:0] seen = 2'b00;
  int lowc, crun, cyc;
  logic clast;

  always_ff @(posedge clk) begin
    if (rst_out === 1'b1) seen <= 2'b01;
    else if (seen == 2'b01) seen <= 2'b11;

    lowc <= rst_pin_n ? 0 : ((lowc < RST_MIN) ? lowc + 1 : lowc);

    if (rst_out) crun <= 0;
    else if (locked ? blk_stb : bit_stb) begin
      crun  <= (crun != 0 && corr_pin == clast) ? ((crun < QUAL_LEN) ? crun + 1 : crun) : 1;
      clast <= corr_pin;
    end

    cyc <= rst_out ? 0 : ((cyc < POL_DELAY) ? cyc + 1 : cyc);
  end

  p_rst_min_low_r1: assert property (@(posedge clk) disable iff (seen != 2'b11)
    $rose(rst_out) |-> lowc >= RST_MIN);

  p_rst_defaults_r2: assert property (@(posedge clk) disable iff (seen != 2'b11)
    rst_out |=> (!corr_en && !smode && !pol_fall));

  p_change_needs_run_r3: assert property (@(posedge clk) disable iff (seen != 2'b11)
    (!$stable(corr_en) && !$past(rst_out)) |-> crun >= QUAL_LEN);

  p_search_no_bit_r4: assert property (@(posedge clk) disable iff (seen != 2'b11)
    (!rst_out && !locked && !bit_stb) |=> ($stable(corr_en) && $stable(smode)));

  p_lock_no_blk_r5: assert property (@(posedge clk) disable iff (seen != 2'b11)
    (!rst_out && locked && !blk_stb) |=> ($stable(corr_en) && $stable(smode)));

  p_pol_hold_r7: assert property (@(posedge clk) disable iff (seen != 2'b11)
    (!rst_out && cyc >= POL_DELAY) |=> $stable(pol_fall));

  p_pol_wait_r7: assert property (@(posedge clk) disable iff (seen != 2'b11)
    (!rst_out && cyc < POL_DELAY - 1) |=> $stable(pol_fall));
endmodule

bind ctl_qual ctl_qual_chk #(.QUAL_LEN(QUAL_LEN), .RST_MIN(RST_MIN), .POL_DELAY(POL_DELAY)) u_chk (.*);

// File: tb/sim_ctl_qual.sv
module sim_ctl_qual;
  localparam int QL = 4;
  localparam int RM = 4;
  localparam int PD = 40;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b1, bit_stb = 1'b0, blk_stb = 1'b0, locked = 1'b0;
  logic corr_pin = 1'b0, smode_pin = 1'b0, pol_pin = 1'b0;
  logic rst_out, corr_en, smode, pol_fall;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctl_qual #(.QUAL_LEN(QL), .RST_MIN(RM), .POL_DELAY(PD)) u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .bit_stb(bit_stb), .blk_stb(blk_stb),
    .locked(locked), .corr_pin(corr_pin), .smode_pin(smode_pin), .pol_pin(pol_pin),
    .rst_out(rst_out), .corr_en(corr_en), .smode(smode), .pol_fall(pol_fall));

  // behavioural reference
  bit m_rst = 0, m_corr = 0, m_smode = 0, m_pol = 0, pdone = 0;
  bit rst_seen = 0, out_ok = 0;
  int lowrun = 0, ptmr = 0;
  bit cq[$];
  bit sq[$];

  function automatic bit allsame(bit q[$]);
    foreach (q[k]) if (q[k] != q[0]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    bit old_rst;
    bit s;
    old_rst = m_rst;
    if (old_rst) begin
      cq.delete(); sq.delete();
      m_corr = 0; m_smode = 0; m_pol = 0; ptmr = 0; pdone = 0;
      if (rst_seen) out_ok = 1;
    end else begin
      s = locked ? blk_stb : bit_stb;
      if (s) begin
        cq.push_back(corr_pin);
        if (cq.size() > QL) void'(cq.pop_front());
        if (cq.size() == QL && allsame(cq)) m_corr = corr_pin;
        sq.push_back(smode_pin);
        if (sq.size() > QL) void'(sq.pop_front());
        if (sq.size() == QL && allsame(sq)) m_smode = smode_pin;
      end
      if (!pdone) begin
        ptmr++;
        if (ptmr == PD) begin m_pol = pol_pin; pdone = 1; end
      end
    end
    if (rst_pin_n) begin lowrun = 0; m_rst = 0; end
    else begin
      lowrun++;
      if (lowrun >= RM) begin m_rst = 1; rst_seen = 1; end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_seen) chk("R1 rst_out vs model", rst_out, m_rst);
    if (out_ok) begin
      chk("R3 corr_en vs model", corr_en, m_corr);
      chk("R6 smode vs model", smode, m_smode);
      chk("R7 pol_fall vs model", pol_fall, m_pol);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(int n);
    repeat (n) begin bit_stb = 1'b1; @(negedge clk); bit_stb = 1'b0; @(negedge clk); end
  endtask

  task automatic pulse_blk(int n);
    repeat (n) begin blk_stb = 1'b1; @(negedge clk); blk_stb = 1'b0; @(negedge clk); end
  endtask

  task automatic do_reset(int lowlen);
    rst_pin_n = 1'b0; step(lowlen); rst_pin_n = 1'b1; step(1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    step(2);
    rst_pin_n = 1'b0; step(5);
    chk("R1 reset after long low", rst_out, 1'b1);
    chk("R2 corr_en default", corr_en, 1'b0);
    chk("R2 smode default", smode, 1'b0);
    chk("R2 pol_fall default", pol_fall, 1'b0);
    rst_pin_n = 1'b1; step(1);
    chk("R1 release", rst_out, 1'b0);

    rst_pin_n = 1'b0; step(3); rst_pin_n = 1'b1; step(1);
    chk("R1 short pulse ignored", rst_out, 1'b0);

    pol_pin = 1'b1;
    locked = 1'b0; corr_pin = 1'b1;
    pulse_blk(5);
    chk("R4 blk_stb ignored while searching", corr_en, 1'b0);
    pulse_bit(3);
    chk("R3 three samples not enough", corr_en, 1'b0);
    pulse_bit(1);
    chk("R4 qualified on bit strobes", corr_en, 1'b1);

    smode_pin = 1'b1; pulse_bit(2);
    smode_pin = 1'b0; pulse_bit(1);
    smode_pin = 1'b1; pulse_bit(3);
    chk("R3 broken run restarts", smode, 1'b0);
    pulse_bit(1);
    chk("R3 run of four", smode, 1'b1);

    step(50);
    chk("R7 polarity captured", pol_fall, 1'b1);
    pol_pin = 1'b0; step(20);
    chk("R7 polarity held", pol_fall, 1'b1);

    locked = 1'b1; corr_pin = 1'b0;
    pulse_bit(6);
    chk("R5 bit_stb ignored while locked", corr_en, 1'b1);
    pulse_blk(4);
    chk("R5 qualified on block strobes", corr_en, 1'b0);
    chk("R6 other control untouched", smode, 1'b1);

    corr_pin = 1'b1; pulse_blk(3);
    do_reset(4);
    chk("R2 defaults after reset", smode, 1'b0);
    locked = 1'b0; pulse_bit(1);
    chk("R8 history cleared by reset", corr_en, 1'b0);
    pulse_bit(3);
    chk("R8 fresh run qualifies", corr_en, 1'b1);

    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 399) == 0) begin
        rst_pin_n = 1'b0; step($urandom_range(1, 6)); rst_pin_n = 1'b1;
      end
      bit_stb   = ($urandom_range(0, 2) == 0);
      blk_stb   = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 199) == 0) locked = ~locked;
      if ($urandom_range(0, 9) == 0) corr_pin = ~corr_pin;
      if ($urandom_range(0, 12) == 0) smode_pin = ~smode_pin;
      if ($urandom_range(0, 7) == 0) pol_pin = ~pol_pin;
      step(1);
    end
    bit_stb = 1'b0; blk_stb = 1'b0; rst_pin_n = 1'b1;
    step(4);
    summary();
  end
endmodule